// File: doc/BRIEF.md
# Bit-Granular Clock-Crossing Gearbox FIFO

This block takes a serial lane that is captured as small bit groups on each edge of a write clock. It hands the same bit stream, in the same order, to an independent read clock as 7-bit words. With double-data-rate capture the lane delivers 2 bits per write cycle. A 4-bit variant is selected with a parameter. Neither group size divides the 7-bit word, so the storage is a 56-bit ring addressed to the single bit. The write side deposits each group at its own bit position. The read side extracts any 7 consecutive bits, and the extraction wraps around the end of the ring.

The two sides exchange progress through counters. The write side counts the groups it has accepted, and the read side counts the words it has delivered. Each counter crosses to the other domain Gray-coded, through a synchronizer chain. From the mirrored count, each side works out how many bits are in flight. The writer refuses a group that would overrun unread bits and raises a sticky overflow flag. The reader hands out a word only when at least seven unread bits are certain to be present. Otherwise it reports a miss in place of the word.

Word alignment is found outside this block. The result is applied once, before the first word, as a bit skip of 0 to 6. The skip moves the first word's start by that many bits.

Top module: `lane_gearbox_fifo`

## Requirements
- R1: While either reset is asserted, and right after release, `rd_valid`, `rd_miss` and `wr_overflow` are 0.
- R2: The written groups form one stream. Bit 0 of `wr_bits` is earliest, and bit 0 of `rd_word` is earliest. Successive words are consecutive 7-bit slices of the stream.
- R3: A group is accepted only if the writer's count of unread bits, plus the group size, is at most 56. A refused group is dropped without a trace in later words, and it sets `wr_overflow`.
- R4: A read request made while fewer than 7 unread bits are known to the reader produces no word. Instead, `rd_miss` is 1 one read cycle later, and `rd_valid` is 0.
- R5: An accepted read request raises `rd_valid` for exactly one read cycle, one read clock edge later. Each accepted request gives exactly one word.
- R6: A pulse on `rd_skip_load` with `rd_skip` = s (0 to 6), given before the first word, discards the first s stream bits. The first word then starts at stream bit s.
- R7: A skip load is ignored if `rd_skip` is 7, or if any word has already been delivered. The word stream continues unchanged.
- R8: Streams much longer than 56 bits keep their order across repeated wraps of the ring.
- R9: `wr_overflow` stays at 1 until the write reset, and the write reset clears it.
- R10: When reads are requested continuously, with the read clock faster than the word rate, every complete word that is written gets delivered. Fewer than 7 bits remain behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | A bit group is presented this write cycle |
| wr_bits | input | IN_W | Bit group; bit 0 is earliest on the lane |
| wr_overflow | output | 1 | Sticky: a group was refused for lack of space |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_skip_load | input | 1 | Apply `rd_skip` as the initial bit skip |
| rd_skip | input | clog2(OUT_W) | Number of leading stream bits to discard |
| rd_word | output | OUT_W | Delivered word; bit 0 is earliest |
| rd_valid | output | 1 | `rd_word` holds a new word this cycle |
| rd_miss | output | 1 | The last request found too few bits |

## Verification
The bench sweeps every skip value from 0 to 7. Each value is paired with its own arithmetic bit pattern and with gaps in the write enable. A wrong bit index, a wrong wrap point or a mishandled skip therefore shows up as a mismatched word. A fill with reads held off separates the exact 56-bit boundary from the first refused group. Resuming reads afterwards shows that the refused bits are absent and that freed space is reused. A single-cycle read request tells the one-edge latency apart from a repeated word. Starting reads on an empty ring separates a miss from a spurious word.

// File: rtl/lane_gbx_pkg.sv
package lane_gbx_pkg;

   // Advance a ring position; pos < ring and step <= ring are assumed.
   function automatic int unsigned ring_add(int unsigned pos, int unsigned step,
                                            int unsigned ring);
      int unsigned s;
      s = pos + step;
      return (s >= ring) ? s - ring : s;
   endfunction

   function automatic logic [31:0] bin_to_gray(logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/lane_gbx_ptr_sync.sv
module lane_gbx_ptr_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_bin,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_bin
);
   import lane_gbx_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("lane_gbx_ptr_sync: STAGES must be at least 2");
   end
   if (W > 32 || W < 2) begin : g_bad_width
      $error("lane_gbx_ptr_sync: W must be 2..32");
   end

   logic [W-1:0]             gray_q;
   logic [STAGES-1:0][W-1:0] stage_q;

   // Launch register: Gray value from a flop, never from logic.
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) gray_q <= '0;
      else            gray_q <= W'(bin_to_gray(32'(src_bin)));
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) stage_q <= '0;
      else            stage_q <= {stage_q[STAGES-2:0], gray_q};
   end

   assign dst_bin = W'(gray_to_bin(32'(stage_q[STAGES-1])));

   // Counter moves by at most one, so at most one Gray bit may flip per edge.
   assert_gray_onebit_R10: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/lane_gbx_wr.sv
module lane_gbx_wr #(
   parameter int IN_W  = 2,
   parameter int OUT_W = 7,
   parameter int RING  = 56,
   parameter int CNT_W = 8
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wr_en,
   input  logic [IN_W-1:0]   wr_bits,
   input  logic [CNT_W-1:0]  rcnt_s,
   output logic [CNT_W-1:0]  wcnt,
   output logic [RING-1:0]   ring_q,
   output logic              wr_overflow
);
   import lane_gbx_pkg::*;

   localparam int POS_W = $clog2(RING);
   localparam logic [CNT_W-1:0] IN_STEP  = CNT_W'(IN_W);
   localparam logic [CNT_W-1:0] OUT_STEP = CNT_W'(OUT_W);
   localparam logic [CNT_W-1:0] RING_C   = CNT_W'(RING);

   logic [POS_W-1:0] wpos;
   logic [CNT_W-1:0] occ;
   logic             room;

   // Unread bits as seen from here; the mirrored read count only lags,
   // so this never underestimates.
   assign occ  = wcnt * IN_STEP - rcnt_s * OUT_STEP;
   assign room = (occ + IN_STEP) <= RING_C;

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wpos        <= '0;
         wcnt        <= '0;
         ring_q      <= '0;
         wr_overflow <= 1'b0;
      end else if (wr_en) begin
         if (room) begin
            for (int j = 0; j < IN_W; j++)
               ring_q[POS_W'(ring_add(32'(wpos), 32'(j), RING))] <= wr_bits[j];
            wpos <= POS_W'(ring_add(32'(wpos), IN_W, RING));
            wcnt <= wcnt + 1'b1;
         end else begin
            wr_overflow <= 1'b1;
         end
      end
   end

   assert_occ_bound_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
      occ <= RING_C);
   assert_ovf_sticky_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_overflow |=> wr_overflow);
   assert_wpos_range_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
      wpos < POS_W'(RING));

endmodule

// File: rtl/lane_gbx_rd.sv
module lane_gbx_rd #(
   parameter int IN_W  = 2,
   parameter int OUT_W = 7,
   parameter int RING  = 56,
   parameter int CNT_W = 8,
   localparam int SKIP_W = $clog2(OUT_W)
) (
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_en,
   input  logic              rd_skip_load,
   input  logic [SKIP_W-1:0] rd_skip,
   input  logic [CNT_W-1:0]  wcnt_s,
   input  logic [RING-1:0]   ring_d,
   output logic [CNT_W-1:0]  rcnt,
   output logic [OUT_W-1:0]  rd_word,
   output logic              rd_valid,
   output logic              rd_miss
);
   import lane_gbx_pkg::*;

   localparam int POS_W = $clog2(RING);
   localparam logic [CNT_W-1:0] IN_STEP  = CNT_W'(IN_W);
   localparam logic [CNT_W-1:0] OUT_STEP = CNT_W'(OUT_W);
   localparam logic [CNT_W-1:0] RING_C   = CNT_W'(RING);

   logic [POS_W-1:0]  rpos;
   logic [SKIP_W-1:0] skip_q;
   logic              started_q;
   logic [CNT_W-1:0]  occ;
   logic              avail, take, do_skip;
   logic [OUT_W-1:0]  word_c;

   // Skipped bits count as consumed; a negative result (MSB set) means
   // the skip has not yet been covered by written data.
   assign occ     = wcnt_s * IN_STEP - rcnt * OUT_STEP - CNT_W'(skip_q);
   assign avail   = !occ[CNT_W-1] && (occ >= OUT_STEP);
   assign take    = rd_en && avail && !rd_skip_load;
   assign do_skip = rd_skip_load && !started_q && (32'(rd_skip) < OUT_W);

   always_comb begin
      for (int i = 0; i < OUT_W; i++)
         word_c[i] = ring_d[POS_W'(ring_add(32'(rpos), 32'(i), RING))];
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rpos      <= '0;
         skip_q    <= '0;
         started_q <= 1'b0;
         rcnt      <= '0;
         rd_word   <= '0;
         rd_valid  <= 1'b0;
         rd_miss   <= 1'b0;
      end else begin
         rd_valid <= take;
         rd_miss  <= rd_en && !rd_skip_load && !avail;
         if (do_skip) begin
            rpos   <= POS_W'(rd_skip);
            skip_q <= rd_skip;
         end else if (take) begin
            rd_word   <= word_c;
            rpos      <= POS_W'(ring_add(32'(rpos), OUT_W, RING));
            rcnt      <= rcnt + 1'b1;
            started_q <= 1'b1;
         end
      end
   end

   assert_valid_or_miss_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
      !(rd_valid && rd_miss));
   assert_one_step_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_valid |-> (rcnt == $past(rcnt) + 1'b1));
   assert_skip_locked_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
      started_q |=> $stable(skip_q));
   assert_rpos_range_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
      rpos < POS_W'(RING));
   assert_occ_bound_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
      occ[CNT_W-1] || (occ <= RING_C));

endmodule

// File: rtl/lane_gearbox_fifo.sv
module lane_gearbox_fifo #(
   parameter int IN_W        = 2,
   parameter int OUT_W       = 7,
   parameter int DEPTH_WORDS = 8,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SKIP_W     = $clog2(OUT_W)
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wr_en,
   input  logic [IN_W-1:0]   wr_bits,
   output logic              wr_overflow,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_en,
   input  logic              rd_skip_load,
   input  logic [SKIP_W-1:0] rd_skip,
   output logic [OUT_W-1:0]  rd_word,
   output logic              rd_valid,
   output logic              rd_miss
);
   localparam int RING = OUT_W * DEPTH_WORDS;

   if (OUT_W < 2) begin : g_bad_out
      $error("lane_gearbox_fifo: OUT_W must be at least 2");
   end
   if (IN_W < 1 || IN_W > RING) begin : g_bad_in
      $error("lane_gearbox_fifo: IN_W must be 1..RING");
   end
   if (CNT_W > 32 || (2 ** (CNT_W - 1)) <= (RING + OUT_W)) begin : g_bad_cnt
      $error("lane_gearbox_fifo: CNT_W too small to resolve ring occupancy");
   end

   logic [CNT_W-1:0] wcnt, wcnt_s, rcnt, rcnt_s;
   logic [RING-1:0]  ring_q;

   lane_gbx_wr #(.IN_W(IN_W), .OUT_W(OUT_W), .RING(RING), .CNT_W(CNT_W)) u_wr (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_bits(wr_bits),
      .rcnt_s(rcnt_s), .wcnt(wcnt), .ring_q(ring_q), .wr_overflow(wr_overflow));

   lane_gbx_ptr_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_w2r (
      .src_clk(wclk), .src_rst_n(wrst_n), .src_bin(wcnt),
      .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_bin(wcnt_s));

   lane_gbx_ptr_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_r2w (
      .src_clk(rclk), .src_rst_n(rrst_n), .src_bin(rcnt),
      .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_bin(rcnt_s));

   lane_gbx_rd #(.IN_W(IN_W), .OUT_W(OUT_W), .RING(RING), .CNT_W(CNT_W)) u_rd (
      .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_skip_load(rd_skip_load),
      .rd_skip(rd_skip), .wcnt_s(wcnt_s), .ring_d(ring_q), .rcnt(rcnt),
      .rd_word(rd_word), .rd_valid(rd_valid), .rd_miss(rd_miss));

endmodule

// File: tb/test_lane_gearbox_fifo.sv
module test_lane_gearbox_fifo;
   localparam int IN_W = 2;
   localparam int OUT_W = 7;

   logic wclk = 1'b0, rclk = 1'b0;
   always #4 wclk = ~wclk;   // 125 MHz write clock
   always #5 rclk = ~rclk;   // unrelated, faster than the word rate

   logic            wrst_n, rrst_n, wr_en, rd_en, rd_skip_load, wr_overflow, rd_valid, rd_miss;
   logic [IN_W-1:0] wr_bits;
   logic [2:0]      rd_skip;
   logic [OUT_W-1:0] rd_word;

   int    checks = 0, errors = 0, drop_n = 0, got_words = 0, wdog = 0;
   bit    exp_q[$];
   string tag = "R2";

   lane_gearbox_fifo i_lane_gearbox_fifo (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_bits(wr_bits),
      .wr_overflow(wr_overflow), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en),
      .rd_skip_load(rd_skip_load), .rd_skip(rd_skip), .rd_word(rd_word),
      .rd_valid(rd_valid), .rd_miss(rd_miss));

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   function automatic logic [1:0] pat(int g, int seed);
      return 2'((g * (seed + 3) + (g >> 2) + seed) & 3);
   endfunction

   // Word checker: each delivered word must equal the next 7 model bits.
   always @(negedge rclk) begin : mon
      int e;
      bit short_q;
      if (rrst_n && rd_valid) begin
         e = 0;
         short_q = 0;
         for (int i = 0; i < OUT_W; i++) begin
            if (exp_q.size() == 0) short_q = 1;
            else e |= int'(exp_q.pop_front()) << i;
         end
         got_words++;
         check(!short_q && int'(rd_word) == e, tag, int'(rd_word), e);
      end
   end

   initial begin
      forever begin
         @(posedge wclk);
         wdog++;
         if (wdog > 150000) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", wdog, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic push_bits(input logic [1:0] b);
      for (int j = 0; j < IN_W; j++) begin
         if (drop_n > 0) drop_n--;
         else exp_q.push_back(b[j]);
      end
   endtask

   task automatic wr_group(input logic [1:0] b, input bit accepted);
      @(negedge wclk);
      wr_en = 1'b1;
      wr_bits = b;
      if (accepted) push_bits(b);
   endtask

   task automatic wr_idle();
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      wrst_n = 1'b0; rrst_n = 1'b0;
      wr_en = 1'b0; wr_bits = '0; rd_en = 1'b0; rd_skip_load = 1'b0; rd_skip = '0;
      exp_q.delete();
      drop_n = 0;
      got_words = 0;
      repeat (3) @(negedge wclk);
      check(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
      check(rd_miss == 1'b0, "R1", int'(rd_miss), 0);
      check(wr_overflow == 1'b0, "R1", int'(wr_overflow), 0);
      @(negedge wclk); wrst_n = 1'b1;
      @(negedge rclk); rrst_n = 1'b1;
      repeat (2) @(negedge rclk);
      check(rd_valid == 1'b0 && rd_miss == 1'b0, "R1", int'(rd_valid), 0);
   endtask

   initial begin
      // Sweep every skip value with gapped writes and continuous reads.
      for (int s = 0; s < 8; s++) begin
         do_reset();
         tag = (s == 0) ? "R8" : ((s == 7) ? "R7" : "R6");
         @(negedge rclk); rd_skip_load = 1'b1; rd_skip = 3'(s);
         @(negedge rclk); rd_skip_load = 1'b0;
         drop_n = (s < OUT_W) ? s : 0;
         rd_en = 1'b1;
         repeat (2) @(negedge rclk);
         check(rd_miss == 1'b1 && rd_valid == 1'b0, "R4", int'(rd_miss), 1);
         fork
            begin
               for (int g = 0; g < 80; g++) begin
                  if (g % 5 == 3) wr_idle();
                  wr_group(pat(g, s), 1'b1);
               end
               wr_idle();
            end
            begin
               // Late skip request: must be ignored (R7).
               repeat (30) @(negedge rclk);
               rd_skip_load = 1'b1; rd_skip = 3'd2;
               @(negedge rclk); rd_skip_load = 1'b0;
            end
         join
         repeat (40) @(negedge rclk);
         check(exp_q.size() < OUT_W, "R10", exp_q.size(), OUT_W - 1);
         check(got_words == (160 - ((s < OUT_W) ? s : 0)) / OUT_W, "R10",
               got_words, (160 - ((s < OUT_W) ? s : 0)) / OUT_W);
      end

      // Fill with reads held off: 28 groups fit exactly, the next two are refused.
      do_reset();
      tag = "R2";
      for (int g = 0; g < 28; g++) wr_group(pat(g, 9), 1'b1);
      wr_idle();
      check(wr_overflow == 1'b0, "R3", int'(wr_overflow), 0);
      wr_group(pat(28, 9), 1'b0);
      wr_group(pat(29, 9), 1'b0);
      wr_idle();
      check(wr_overflow == 1'b1, "R3", int'(wr_overflow), 1);
      repeat (10) @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      check(rd_valid == 1'b1, "R5", int'(rd_valid), 1);
      rd_en = 1'b0;
      @(negedge rclk);
      check(rd_valid == 1'b0 && got_words == 1, "R5", got_words, 1);
      rd_en = 1'b1;
      repeat (30) @(negedge rclk);
      check(got_words == 8 && exp_q.size() == 0, "R3", got_words, 8);
      tag = "R3";
      for (int g = 30; g < 58; g++) wr_group(pat(g, 9), 1'b1);
      wr_idle();
      repeat (30) @(negedge rclk);
      check(got_words == 16, "R3", got_words, 16);
      check(wr_overflow == 1'b1, "R9", int'(wr_overflow), 1);
      do_reset();
      check(wr_overflow == 1'b0, "R9", int'(wr_overflow), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule